// File: doc/BRIEF.md
# SPI Status and Interrupt Flag Unit

This block holds the sticky status flags of a serial peripheral interface and turns them into one interrupt line and two DMA request lines. The shift engine beside it reports single-cycle events (transmit buffer drained, byte received, mode fault, CRC mismatch, wakeup), and the register block reports single-cycle accesses (data write, data read, status read, status write, control-register-1 write). The unit keeps the flags, holds the last received byte, and drives a status word that the register block returns on status reads.

Flags do not use a write-one-to-clear scheme. The overrun flag clears only after a data read followed by a later status read. The mode-fault flag clears only after a status access followed by a later control-register-1 write. The CRC-error and wakeup flags clear when a status write puts 0 in their bit position. A hardware event in the same cycle as a clear always wins.

Top module: `spi_flag_unit`

## Requirements
- R1: After reset the status word shows only the transmit-empty flag (bit 1) plus the busy bit, `irq` is 0 and both DMA requests are 0.
- R2: Status bits: 0 receive-not-empty, 1 transmit-empty, 3 wakeup, 4 CRC error, 5 mode fault, 6 overrun, 7 busy (follows `busy_in` without delay). Bit 2 and any bits above 7 read 0.
- R3: A data write clears transmit-empty. The transmit-drained event sets it.
- R4: A received-byte event sets receive-not-empty and loads `rx_byte` into `rx_data`. A data read clears receive-not-empty.
- R5: A received-byte event while receive-not-empty is set, with no data read in that cycle, sets overrun. In that case receive-not-empty stays set and `rx_data` keeps the old byte. A byte arriving in the same cycle as a data read is accepted normally.
- R6: Overrun clears only when a status read follows, in a later cycle, a data read made while overrun was set. A status read alone, or one made before the data read, leaves it set.
- R7: Mode fault clears only when a control-register-1 write follows, in a later cycle, a status read or write made while mode fault was set. A control write alone, or one after an access made before the fault, leaves it set.
- R8: A status write clears wakeup if bit 3 of the written value is 0, and clears CRC error if bit 4 is 0. Writing 1 leaves the flag as it is, and the other bits of the written value are ignored.
- R9: When a set event and a clear happen in the same cycle, the flag ends up set.
- R10: `irq` = (tx enable AND transmit-empty) OR (rx enable AND receive-not-empty) OR (error enable AND (CRC error OR mode fault OR overrun)) OR (wakeup enable AND wakeup). It follows enable changes in the same cycle.
- R11: `dma_tx_req` = DMA-TX enable AND transmit-empty. `dma_rx_req` = DMA-RX enable AND receive-not-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_tx_drained | input | 1 | Transmit buffer moved into the shifter |
| ev_rx_byte | input | 1 | A received byte is available on `rx_byte` |
| rx_byte | input | DATA_W | Received byte from the shifter |
| ev_mode_fault | input | 1 | Mode fault detected |
| ev_crc_bad | input | 1 | CRC comparison failed |
| ev_wake | input | 1 | Wakeup event |
| busy_in | input | 1 | Live busy state of the shift engine |
| acc_dr_wr | input | 1 | Data register write strobe |
| acc_dr_rd | input | 1 | Data register read strobe |
| acc_sr_rd | input | 1 | Status register read strobe |
| acc_sr_wr | input | 1 | Status register write strobe |
| sr_wdata | input | SR_W | Value written to the status register |
| acc_cr1_wr | input | 1 | Control register 1 write strobe |
| ie_tx | input | 1 | Transmit-empty interrupt enable |
| ie_rx | input | 1 | Receive-not-empty interrupt enable |
| ie_err | input | 1 | Shared error interrupt enable |
| ie_wake | input | 1 | Wakeup interrupt enable |
| dma_tx_en | input | 1 | DMA transmit request enable |
| dma_rx_en | input | 1 | DMA receive request enable |
| status_o | output | SR_W | Status word |
| rx_data | output | DATA_W | Held received byte |
| irq | output | 1 | Combined interrupt |
| dma_tx_req | output | 1 | DMA transmit request |
| dma_rx_req | output | 1 | DMA receive request |

## Verification
The hardest cases are the ordering conditions of the two sequence clears. To reach them, the stimulus table builds an overrun with two back-to-back received bytes and then applies the accesses in both orders. It also issues a status access while mode fault is still clear and only then raises the fault, which checks that a status access made before the flag was set does not enable the later control write to clear it. Same-cycle set/clear collisions are placed in single table rows so that each flag sees the event and the clear strobe on one edge.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
   // indices into the sticky-flag vector
   localparam int FI_RXNE = 0;
   localparam int FI_TXE  = 1;
   localparam int FI_WAKE = 2;
   localparam int FI_CRC  = 3;
   localparam int FI_MODF = 4;
   localparam int FI_OVR  = 5;
   localparam int NFLAG   = 6;
   localparam logic [NFLAG-1:0] FLAG_RST = 6'b000010;

   // positions in the status word (software-visible)
   localparam int SB_RXNE = 0;
   localparam int SB_TXE  = 1;
   localparam int SB_WAKE = 3;
   localparam int SB_CRC  = 4;
   localparam int SB_MODF = 5;
   localparam int SB_OVR  = 6;
   localparam int SB_BSY  = 7;
   localparam int SB_MIN_W = 8;
endpackage

// File: rtl/spi_sticky_flag.sv
module spi_sticky_flag #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= RST_VAL;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o); // R9
   AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o); // R9
endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_ev,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              full_q,
   input  logic              rd_i,
   output logic              accept_o,
   output logic              overrun_o,
   output logic [DATA_W-1:0] data_o
);
   // a read in the same cycle frees the slot for the incoming byte
   assign accept_o  = byte_ev && (!full_q || rd_i);
   assign overrun_o = byte_ev && full_q && !rd_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        data_o <= '0;
      else if (accept_o) data_o <= byte_in;
   end

   AST_HOLD_ON_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_ev && full_q && !rd_i) |=> $stable(data_o)); // R5
   AST_LOAD_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_ev && !full_q) |=> (data_o == $past(byte_in))); // R4
endmodule

// File: rtl/spi_seq_clear.sv
module spi_seq_clear (
   input  logic clk,
   input  logic rst_n,
   input  logic ovr_q,
   input  logic modf_q,
   input  logic dr_rd,
   input  logic sr_rd,
   input  logic sr_wr,
   input  logic cr1_wr,
   output logic ovr_clr_o,
   output logic modf_clr_o
);
   logic ovr_arm_q, modf_arm_q;

   // second step of each sequence consumes an arm set by an earlier first step
   assign ovr_clr_o  = sr_rd  && ovr_arm_q;
   assign modf_clr_o = cr1_wr && modf_arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_arm_q  <= 1'b0;
         modf_arm_q <= 1'b0;
      end else begin
         if (sr_rd)               ovr_arm_q <= 1'b0;
         else if (dr_rd && ovr_q) ovr_arm_q <= 1'b1;

         if (cr1_wr)                         modf_arm_q <= 1'b0;
         else if ((sr_rd || sr_wr) && modf_q) modf_arm_q <= 1'b1;
      end
   end

   AST_OVR_ARM_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_arm_q) |-> $past(dr_rd)); // R6
   AST_MODF_ARM_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(modf_arm_q) |-> ($past(sr_rd) || $past(sr_wr))); // R7
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
   import spi_flag_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SR_W    = 8,
   parameter bit BSY_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_tx_drained,
   input  logic              ev_rx_byte,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              ev_mode_fault,
   input  logic              ev_crc_bad,
   input  logic              ev_wake,
   input  logic              busy_in,
   input  logic              acc_dr_wr,
   input  logic              acc_dr_rd,
   input  logic              acc_sr_rd,
   input  logic              acc_sr_wr,
   input  logic [SR_W-1:0]   sr_wdata,
   input  logic              acc_cr1_wr,
   input  logic              ie_tx,
   input  logic              ie_rx,
   input  logic              ie_err,
   input  logic              ie_wake,
   input  logic              dma_tx_en,
   input  logic              dma_rx_en,
   output logic [SR_W-1:0]   status_o,
   output logic [DATA_W-1:0] rx_data,
   output logic              irq,
   output logic              dma_tx_req,
   output logic              dma_rx_req
);
   generate
      if (SR_W < SB_MIN_W) begin : g_bad_sr_w
         $error("spi_flag_unit: SR_W must be at least %0d", SB_MIN_W);
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("spi_flag_unit: DATA_W must be positive");
      end
   endgenerate

   logic [NFLAG-1:0] flag_q, flag_set, flag_clr;
   logic rx_accept, rx_overrun, ovr_clr, modf_clr, busy_v;
   logic unused_wdata;
   assign unused_wdata = ^sr_wdata;

   spi_rx_hold #(.DATA_W(DATA_W)) u_rx_hold (
      .clk(clk), .rst_n(rst_n), .byte_ev(ev_rx_byte), .byte_in(rx_byte),
      .full_q(flag_q[FI_RXNE]), .rd_i(acc_dr_rd),
      .accept_o(rx_accept), .overrun_o(rx_overrun), .data_o(rx_data));

   spi_seq_clear u_seq (
      .clk(clk), .rst_n(rst_n), .ovr_q(flag_q[FI_OVR]), .modf_q(flag_q[FI_MODF]),
      .dr_rd(acc_dr_rd), .sr_rd(acc_sr_rd), .sr_wr(acc_sr_wr), .cr1_wr(acc_cr1_wr),
      .ovr_clr_o(ovr_clr), .modf_clr_o(modf_clr));

   always_comb begin
      flag_set           = '0;
      flag_clr           = '0;
      flag_set[FI_RXNE]  = rx_accept;
      flag_clr[FI_RXNE]  = acc_dr_rd;
      flag_set[FI_TXE]   = ev_tx_drained;
      flag_clr[FI_TXE]   = acc_dr_wr;
      flag_set[FI_WAKE]  = ev_wake;
      flag_clr[FI_WAKE]  = acc_sr_wr && !sr_wdata[SB_WAKE];
      flag_set[FI_CRC]   = ev_crc_bad;
      flag_clr[FI_CRC]   = acc_sr_wr && !sr_wdata[SB_CRC];
      flag_set[FI_MODF]  = ev_mode_fault;
      flag_clr[FI_MODF]  = modf_clr;
      flag_set[FI_OVR]   = rx_overrun;
      flag_clr[FI_OVR]   = ovr_clr;
   end

   generate
      for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
         spi_sticky_flag #(.RST_VAL(FLAG_RST[gi])) u_flag (
            .clk(clk), .rst_n(rst_n), .set_i(flag_set[gi]), .clr_i(flag_clr[gi]),
            .q_o(flag_q[gi]));
      end

      if (BSY_REG) begin : g_bsy_reg
         logic bsy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bsy_q <= 1'b0;
            else        bsy_q <= busy_in;
         end
         assign busy_v = bsy_q;
      end else begin : g_bsy_live
         assign busy_v = busy_in;
      end
   endgenerate

   always_comb begin
      status_o          = '0;
      status_o[SB_RXNE] = flag_q[FI_RXNE];
      status_o[SB_TXE]  = flag_q[FI_TXE];
      status_o[SB_WAKE] = flag_q[FI_WAKE];
      status_o[SB_CRC]  = flag_q[FI_CRC];
      status_o[SB_MODF] = flag_q[FI_MODF];
      status_o[SB_OVR]  = flag_q[FI_OVR];
      status_o[SB_BSY]  = busy_v;
   end

   assign irq = (ie_tx   && flag_q[FI_TXE])
             || (ie_rx   && flag_q[FI_RXNE])
             || (ie_err  && (flag_q[FI_CRC] || flag_q[FI_MODF] || flag_q[FI_OVR]))
             || (ie_wake && flag_q[FI_WAKE]);
   assign dma_tx_req = dma_tx_en && flag_q[FI_TXE];
   assign dma_rx_req = dma_rx_en && flag_q[FI_RXNE];

   AST_OVR_FALL_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_o[SB_OVR]) |-> $past(acc_sr_rd)); // R6
   AST_MODF_FALL_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_o[SB_MODF]) |-> $past(acc_cr1_wr)); // R7
   AST_OVERRUN_KEEPS_RXNE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rx_byte && status_o[SB_RXNE] && !acc_dr_rd) |=> (status_o[SB_OVR] && status_o[SB_RXNE])); // R5
   AST_TXE_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tx_drained |=> status_o[SB_TXE]); // R3
endmodule

// File: tb/spi_flag_unit_tb.sv
module spi_flag_unit_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic ev_tx_drained, ev_rx_byte, ev_mode_fault, ev_crc_bad, ev_wake, busy_in;
   logic [7:0] rx_byte, sr_wdata, status_o, rx_data;
   logic acc_dr_wr, acc_dr_rd, acc_sr_rd, acc_sr_wr, acc_cr1_wr;
   logic ie_tx, ie_rx, ie_err, ie_wake, dma_tx_en, dma_rx_en;
   logic irq, dma_tx_req, dma_rx_req;

   spi_flag_unit u_dut (
      .clk(clk), .rst_n(rst_n), .ev_tx_drained(ev_tx_drained), .ev_rx_byte(ev_rx_byte),
      .rx_byte(rx_byte), .ev_mode_fault(ev_mode_fault), .ev_crc_bad(ev_crc_bad),
      .ev_wake(ev_wake), .busy_in(busy_in), .acc_dr_wr(acc_dr_wr), .acc_dr_rd(acc_dr_rd),
      .acc_sr_rd(acc_sr_rd), .acc_sr_wr(acc_sr_wr), .sr_wdata(sr_wdata),
      .acc_cr1_wr(acc_cr1_wr), .ie_tx(ie_tx), .ie_rx(ie_rx), .ie_err(ie_err),
      .ie_wake(ie_wake), .dma_tx_en(dma_tx_en), .dma_rx_en(dma_rx_en),
      .status_o(status_o), .rx_data(rx_data), .irq(irq),
      .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req));

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   // row: {ev[tx,rx,modf,crc,wake], acc[dr_wr,dr_rd,sr_rd,sr_wr,cr1_wr], wdata, rxbyte, exp_status, exp_rx}
   localparam int NROW = 32;
   localparam logic [41:0] TBL [NROW] = '{
      {5'b00000, 5'b10000, 8'h00, 8'h00, 8'h00, 8'h00}, // 0  R3 data write clears TXE
      {5'b10000, 5'b00000, 8'h00, 8'h00, 8'h02, 8'h00}, // 1  R3
      {5'b01000, 5'b00000, 8'h00, 8'hA5, 8'h03, 8'hA5}, // 2  R4
      {5'b01000, 5'b00000, 8'h00, 8'h3C, 8'h43, 8'hA5}, // 3  R5 overrun
      {5'b00000, 5'b00100, 8'h00, 8'h00, 8'h43, 8'hA5}, // 4  R6 status read alone
      {5'b00000, 5'b01000, 8'h00, 8'h00, 8'h42, 8'hA5}, // 5  R4 R6
      {5'b00000, 5'b00100, 8'h00, 8'h00, 8'h02, 8'hA5}, // 6  R6 sequence done
      {5'b00100, 5'b00000, 8'h00, 8'h00, 8'h22, 8'hA5}, // 7  R7
      {5'b00000, 5'b00001, 8'h00, 8'h00, 8'h22, 8'hA5}, // 8  R7 control write alone
      {5'b00000, 5'b00100, 8'h00, 8'h00, 8'h22, 8'hA5}, // 9  R7
      {5'b00000, 5'b00001, 8'h00, 8'h00, 8'h02, 8'hA5}, // 10 R7
      {5'b00011, 5'b00000, 8'h00, 8'h00, 8'h1A, 8'hA5}, // 11 R8
      {5'b00000, 5'b00010, 8'hFF, 8'h00, 8'h1A, 8'hA5}, // 12 R8 ones keep
      {5'b00000, 5'b00010, 8'hF7, 8'h00, 8'h12, 8'hA5}, // 13 R8
      {5'b00000, 5'b00010, 8'hEF, 8'h00, 8'h02, 8'hA5}, // 14 R8
      {5'b01000, 5'b01000, 8'h00, 8'h5A, 8'h03, 8'h5A}, // 15 R9
      {5'b01000, 5'b01000, 8'h00, 8'h77, 8'h03, 8'h77}, // 16 R5 read frees slot
      {5'b00000, 5'b01000, 8'h00, 8'h00, 8'h02, 8'h77}, // 17 R4
      {5'b10000, 5'b10000, 8'h00, 8'h00, 8'h02, 8'h77}, // 18 R9
      {5'b00010, 5'b00010, 8'h00, 8'h00, 8'h12, 8'h77}, // 19 R9
      {5'b00000, 5'b00010, 8'hEF, 8'h00, 8'h02, 8'h77}, // 20 R8
      {5'b00000, 5'b00100, 8'h00, 8'h00, 8'h02, 8'h77}, // 21 R7 access before fault
      {5'b00100, 5'b00000, 8'h00, 8'h00, 8'h22, 8'h77}, // 22 R7
      {5'b00000, 5'b00001, 8'h00, 8'h00, 8'h22, 8'h77}, // 23 R7 not armed
      {5'b00000, 5'b00010, 8'hFF, 8'h00, 8'h22, 8'h77}, // 24 R7 status write arms
      {5'b00000, 5'b00001, 8'h00, 8'h00, 8'h02, 8'h77}, // 25 R7
      {5'b01000, 5'b00000, 8'h00, 8'h11, 8'h03, 8'h11}, // 26 R4
      {5'b01000, 5'b00000, 8'h00, 8'h22, 8'h43, 8'h11}, // 27 R5
      {5'b00000, 5'b00100, 8'h00, 8'h00, 8'h43, 8'h11}, // 28 R6 wrong order
      {5'b00000, 5'b01000, 8'h00, 8'h00, 8'h42, 8'h11}, // 29 R6
      {5'b00000, 5'b01000, 8'h00, 8'h00, 8'h42, 8'h11}, // 30 R6
      {5'b00000, 5'b00100, 8'h00, 8'h00, 8'h02, 8'h11}  // 31 R6
   };

   function automatic string row_req(int r);
      if (r <= 1) return "R3";
      if (r == 2 || r == 17 || r == 26) return "R4";
      if (r == 3 || r == 16 || r == 27) return "R5";
      if ((r >= 4 && r <= 6) || r >= 28) return "R6";
      if ((r >= 7 && r <= 10) || (r >= 21 && r <= 25)) return "R7";
      if ((r >= 11 && r <= 14) || r == 20) return "R8";
      return "R9";
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      {ev_tx_drained, ev_rx_byte, ev_mode_fault, ev_crc_bad, ev_wake} = '0;
      {acc_dr_wr, acc_dr_rd, acc_sr_rd, acc_sr_wr, acc_cr1_wr} = '0;
      sr_wdata = 8'h00;
      rx_byte  = 8'h00;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle();
      busy_in = 1'b1;
      {ie_tx, ie_rx, ie_err, ie_wake, dma_tx_en, dma_rx_en} = '0;
      repeat (3) @(negedge clk);
      // R1 R2: reset state, busy bit live, bit 2 zero
      check(status_o == 8'h82, "R1", "reset status", status_o, 8'h82);
      check({irq, dma_tx_req, dma_rx_req} == 3'b000, "R1", "reset outputs",
            {5'b0, irq, dma_tx_req, dma_rx_req}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      busy_in = 1'b0;
      #1;
      check(status_o == 8'h02, "R2", "busy follows input", status_o, 8'h02);

      for (int r = 0; r < NROW; r++) begin
         {ev_tx_drained, ev_rx_byte, ev_mode_fault, ev_crc_bad, ev_wake} = TBL[r][41:37];
         {acc_dr_wr, acc_dr_rd, acc_sr_rd, acc_sr_wr, acc_cr1_wr} = TBL[r][36:32];
         sr_wdata = TBL[r][31:24];
         rx_byte  = TBL[r][23:16];
         @(negedge clk);
         idle();
         check(status_o == TBL[r][15:8], row_req(r), $sformatf("row %0d status", r),
               status_o, TBL[r][15:8]);
         check(rx_data == TBL[r][7:0], row_req(r), $sformatf("row %0d rx_data", r),
               rx_data, TBL[r][7:0]);
      end

      // state now: TXE only
      ie_tx = 1'b1; #1;
      check(irq == 1'b1, "R10", "tx enable with TXE", {7'b0, irq}, 8'h01);
      ie_tx = 1'b0; #1;
      check(irq == 1'b0, "R10", "tx masked", {7'b0, irq}, 8'h00);
      ev_mode_fault = 1'b1;
      @(negedge clk); idle();
      ie_err = 1'b1; #1;
      check(irq == 1'b1, "R10", "error enable with MODF", {7'b0, irq}, 8'h01);
      ie_err = 1'b0; ie_wake = 1'b1; #1;
      check(irq == 1'b0, "R10", "wake enable without WKUP", {7'b0, irq}, 8'h00);
      dma_tx_en = 1'b1; dma_rx_en = 1'b1; #1;
      check(dma_tx_req == 1'b1, "R11", "tx dma with TXE", {7'b0, dma_tx_req}, 8'h01);
      check(dma_rx_req == 1'b0, "R11", "rx dma without RXNE", {7'b0, dma_rx_req}, 8'h00);
      ev_rx_byte = 1'b1; rx_byte = 8'hC3;
      @(negedge clk); idle();
      check(dma_rx_req == 1'b1, "R11", "rx dma with RXNE", {7'b0, dma_rx_req}, 8'h01);
      check(irq == 1'b0, "R10", "rx masked", {7'b0, irq}, 8'h00);
      ie_rx = 1'b1; #1;
      check(irq == 1'b1, "R10", "rx enable with RXNE", {7'b0, irq}, 8'h01);
      dma_tx_en = 1'b0; #1;
      check(dma_tx_req == 1'b0, "R11", "tx dma disabled", {7'b0, dma_tx_req}, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule